// File: doc/BRIEF.md
# Serial ADC Host Controller

This block drives a 12-bit serial analog-to-digital converter over three wires: a serial clock it generates, a convert-start strobe it generates, and a serial data line it reads. A one-cycle start request launches a conversion. The controller first raises the convert strobe. After a fixed setup margin, it runs the serial clock and shifts in a reference-ready flag followed by twelve data bits, most significant first. The flag and word are then held on a parallel output under a valid/ready handshake.

The same converter is put to sleep by holding the serial clock low and pulsing the convert strobe. Two pulses select the light power-down state and four pulses select the deep state. A wake command runs throwaway conversions, because the clock edges of a conversion wake the converter. These conversions repeat until the returned flag reads 1. If the flag is still 0 after a set number of tries, an error flag is raised. All timing is counted in system clock ticks and set through parameters.

Top module: `sadc_host`

## Requirements
- R1: After reset, the serial clock, the convert strobe, res_valid_o and wake_err_o are all low.
- R2: An accepted start raises the convert strobe for CONV_TICKS cycles while the serial clock is low. The first serial clock rise follows exactly SETUP_TICKS cycles after the strobe rises.
- R3: Each conversion gives exactly 14 serial clock rises. The line is sampled on rises 2 to 14, so the first sampled bit appears on res_ref_o and the next twelve appear on res_data_o[11:0], MSB first.
- R4: Within a conversion, the serial clock rises every 2*HALF_TICKS cycles, and the data line is sampled at the system edge that raises the clock.
- R5: A start request made while a conversion is running or a result is being held has no effect: it produces no convert pulse and no extra result.
- R6: res_valid_o, once high, stays high with res_data_o and res_ref_o unchanged until a cycle with res_ready_i high. Each normal conversion gives exactly one result.
- R7: Mode command 1 (nap) gives exactly two convert pulses, CONV_TICKS high and CONV_TICKS low, with the serial clock held low and no result.
- R8: Mode command 2 (sleep) gives exactly four convert pulses under the same conditions as R7.
- R9: Mode command 0 (wake) repeats full conversions until the captured flag is 1. These conversions present no result and leave wake_err_o low.
- R10: If WAKE_TRIES wake conversions all return a flag of 0, wake_err_o goes high. It is cleared in the cycle after the next accepted wake command.
- R11: Mode commands are accepted only when idle, and code 3 has no effect. When a start and a valid mode command arrive in the same idle cycle, the mode command is served and the start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, one cycle |
| mode_set_i | input | 1 | Mode command strobe |
| mode_i | input | 2 | Mode code: 0 wake, 1 nap, 2 sleep, 3 reserved |
| adc_sclk_o | output | 1 | Serial clock to converter |
| adc_conv_o | output | 1 | Convert-start strobe to converter |
| adc_sdata_i | input | 1 | Serial data from converter |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result accepted by consumer |
| res_data_o | output | DW | Converted word |
| res_ref_o | output | 1 | Reference-ready flag of the result |
| wake_err_o | output | 1 | Wake timeout flag |

## Verification
Two things can collide in the same idle cycle: a conversion request and a power-mode command. The bench raises start_i and mode_set_i on the same edge. It then counts convert pulses and serial clock rises at the converter model, expecting the pulse count of the mode and no clock rise. A second collision is a start request that lands while a result is held or while a conversion is shifting in. Here the bench counts convert pulses across the whole transaction and requires exactly one.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_SHIFT,
        ST_OUT,
        ST_PHI,
        ST_PLO
    } sadc_st_e;

    localparam logic [1:0] MODE_WAKE  = 2'd0;
    localparam logic [1:0] MODE_NAP   = 2'd1;
    localparam logic [1:0] MODE_SLEEP = 2'd2;

    localparam int NAP_PULSES   = 2;
    localparam int SLEEP_PULSES = 4;

endpackage

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
    parameter int NB = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          smp_i,
    input  logic          din_i,
    output logic [NB-1:0] word_o
);

    logic [NB-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (clr_i) begin
            sr_d = '0;
        end else if (smp_i) begin
            sr_d = {sr_q[NB-2:0], din_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word_o = sr_q;

endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
    import sadc_pkg::*;
#(
    parameter int NB          = 13,
    parameter int HALF_TICKS  = 2,
    parameter int CONV_TICKS  = 2,
    parameter int SETUP_TICKS = 4,
    parameter int WAKE_TRIES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       mode_set_i,
    input  logic [1:0] mode_i,
    input  logic       ref_i,
    input  logic       res_ready_i,
    output logic       sclk_o,
    output logic       conv_o,
    output logic       valid_o,
    output logic       err_o,
    output logic       clr_o,
    output logic       smp_o
);

    localparam int TMAX = (SETUP_TICKS > HALF_TICKS) ?
                          ((SETUP_TICKS > CONV_TICKS) ? SETUP_TICKS : CONV_TICKS) :
                          ((HALF_TICKS > CONV_TICKS) ? HALF_TICKS : CONV_TICKS);
    localparam int TW  = $clog2(TMAX + 1);
    localparam int EW  = $clog2(NB + 2);
    localparam int RW  = $clog2(WAKE_TRIES + 1);

    typedef struct packed {
        sadc_st_e       st;
        logic [TW-1:0]  tick;
        logic [EW-1:0]  edges;
        logic [2:0]     pcnt;
        logic [RW-1:0]  tries;
        logic           conv;
        logic           sclk;
        logic           dummy;
        logic           valid;
        logic           err;
    } ctrl_s;

    ctrl_s r_d, r_q;

    always_comb begin
        r_d   = r_q;
        clr_o = 1'b0;
        smp_o = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (mode_set_i && mode_i != 2'd3) begin
                    r_d.tick = '0;
                    if (mode_i == MODE_WAKE) begin
                        r_d.err   = 1'b0;
                        r_d.dummy = 1'b1;
                        r_d.tries = '0;
                        r_d.st    = ST_CONV;
                        r_d.conv  = 1'b1;
                        clr_o     = 1'b1;
                    end else begin
                        r_d.st   = ST_PHI;
                        r_d.conv = 1'b1;
                        r_d.pcnt = (mode_i == MODE_NAP) ? 3'(NAP_PULSES) : 3'(SLEEP_PULSES);
                    end
                end else if (start_i) begin
                    r_d.dummy = 1'b0;
                    r_d.tick  = '0;
                    r_d.st    = ST_CONV;
                    r_d.conv  = 1'b1;
                    clr_o     = 1'b1;
                end
            end
            ST_CONV: begin
                r_d.tick = r_q.tick + 1'b1;
                r_d.conv = (int'(r_q.tick) + 1 < CONV_TICKS);
                if (r_q.tick == TW'(SETUP_TICKS - 1)) begin
                    r_d.tick  = '0;
                    r_d.sclk  = 1'b1;
                    r_d.edges = EW'(1);
                    r_d.st    = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                r_d.tick = r_q.tick + 1'b1;
                if (r_q.tick == TW'(HALF_TICKS - 1)) begin
                    r_d.tick = '0;
                    r_d.sclk = !r_q.sclk;
                    if (!r_q.sclk) begin
                        smp_o     = 1'b1;
                        r_d.edges = r_q.edges + 1'b1;
                    end else if (r_q.edges == EW'(NB + 1)) begin
                        if (!r_q.dummy) begin
                            r_d.st    = ST_OUT;
                            r_d.valid = 1'b1;
                        end else if (ref_i) begin
                            r_d.st    = ST_IDLE;
                            r_d.dummy = 1'b0;
                        end else if (r_q.tries == RW'(WAKE_TRIES - 1)) begin
                            r_d.st    = ST_IDLE;
                            r_d.dummy = 1'b0;
                            r_d.err   = 1'b1;
                        end else begin
                            r_d.tries = r_q.tries + 1'b1;
                            r_d.st    = ST_CONV;
                            r_d.conv  = 1'b1;
                            clr_o     = 1'b1;
                        end
                    end
                end
            end
            ST_OUT: begin
                if (res_ready_i) begin
                    r_d.valid = 1'b0;
                    r_d.st    = ST_IDLE;
                end
            end
            ST_PHI: begin
                r_d.tick = r_q.tick + 1'b1;
                if (r_q.tick == TW'(CONV_TICKS - 1)) begin
                    r_d.tick = '0;
                    r_d.conv = 1'b0;
                    r_d.pcnt = r_q.pcnt - 1'b1;
                    r_d.st   = ST_PLO;
                end
            end
            ST_PLO: begin
                r_d.tick = r_q.tick + 1'b1;
                if (r_q.tick == TW'(CONV_TICKS - 1)) begin
                    r_d.tick = '0;
                    if (r_q.pcnt == 3'd0) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.conv = 1'b1;
                        r_d.st   = ST_PHI;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk_o  = r_q.sclk;
    assign conv_o  = r_q.conv;
    assign valid_o = r_q.valid;
    assign err_o   = r_q.err;

    // R2: a convert strobe never starts while the serial clock is high
    a_r2_conv_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.conv) |-> !r_q.sclk);

    // R7 / R8: power-down pulses run with the serial clock held low
    a_r7_pulse_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PHI || r_q.st == ST_PLO) |-> !sclk_o);

    // R5: no new conversion launched while a result is held
    a_r5_no_conv_held: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.valid && !res_ready_i) |=> !conv_o);

    // R10: the error flag only rises at the end of a wake sequence
    a_r10_err_from_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(r_q.dummy));

    // R11: mode command seen in a busy state leaves the state unchanged
    a_r11_busy_mode_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OUT && mode_set_i && !res_ready_i) |=> r_q.st == ST_OUT);

endmodule

// File: rtl/sadc_host.sv
module sadc_host #(
    parameter int DW          = 12,
    parameter int HALF_TICKS  = 2,
    parameter int CONV_TICKS  = 2,
    parameter int SETUP_TICKS = 4,
    parameter int WAKE_TRIES  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_set_i,
    input  logic [1:0]    mode_i,
    output logic          adc_sclk_o,
    output logic          adc_conv_o,
    input  logic          adc_sdata_i,
    output logic          res_valid_o,
    input  logic          res_ready_i,
    output logic [DW-1:0] res_data_o,
    output logic          res_ref_o,
    output logic          wake_err_o
);

    localparam int NB = DW + 1;

    logic          clr, smp;
    logic [NB-1:0] word;

    sadc_ctrl #(
        .NB          (NB),
        .HALF_TICKS  (HALF_TICKS),
        .CONV_TICKS  (CONV_TICKS),
        .SETUP_TICKS (SETUP_TICKS),
        .WAKE_TRIES  (WAKE_TRIES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_set_i  (mode_set_i),
        .mode_i      (mode_i),
        .ref_i       (word[NB-1]),
        .res_ready_i (res_ready_i),
        .sclk_o      (adc_sclk_o),
        .conv_o      (adc_conv_o),
        .valid_o     (res_valid_o),
        .err_o       (wake_err_o),
        .clr_o       (clr),
        .smp_o       (smp)
    );

    sadc_shifter #(.NB(NB)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .smp_i  (smp),
        .din_i  (adc_sdata_i),
        .word_o (word)
    );

    assign res_data_o = word[DW-1:0];
    assign res_ref_o  = word[NB-1];

    // R6: a held result keeps its value until it is taken
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(word)));

endmodule

// File: tb/sadc_host_tb.sv
`timescale 1ns/1ps
module sadc_host_tb;

    localparam int DW = 12, HALF = 2, CONVT = 2, SETUP = 4, TRIES = 4;
    localparam int TCK = 5;

    logic clk = 0, rst_n = 0;
    logic start = 0, mset = 0, rdy = 0;
    logic [1:0] mode = 0;
    logic sclk, conv, sdata = 0, valid, rref, werr;
    logic [DW-1:0] rdata;

    int n_chk = 0, n_fail = 0;

    always #(TCK/2.0) clk = ~clk;

    sadc_host #(.DW(DW), .HALF_TICKS(HALF), .CONV_TICKS(CONVT),
                .SETUP_TICKS(SETUP), .WAKE_TRIES(TRIES)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_set_i(mset), .mode_i(mode),
        .adc_sclk_o(sclk), .adc_conv_o(conv), .adc_sdata_i(sdata),
        .res_valid_o(valid), .res_ready_i(rdy), .res_data_o(rdata),
        .res_ref_o(rref), .wake_err_o(werr));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // converter model
    int conv_rises = 0, clk_rises = 0, pulses = 0, convs_ss = 1000, ready_after = 0, idx = 99;
    logic [DW-1:0] adc_word = 0;
    logic [DW:0] stream = 0;
    longint t_conv = 0, t_rise = 0;
    int pulse_hi_start = 0;

    always @(posedge conv) begin
        conv_rises++;
        pulses++;
        t_conv = $time;
        if (pulses == 4) convs_ss = 0;
    end

    always @(negedge conv) begin
        if (rst_n) chk(($time - t_conv) == CONVT*TCK, "R2", "convert pulse width ns",
                       $time - t_conv, CONVT*TCK);
    end

    always @(posedge sclk) begin
        clk_rises++;
        if (pulses > 0) begin
            convs_ss++;
            chk(($time - t_conv) == SETUP*TCK, "R2", "setup from strobe to first rise ns",
                $time - t_conv, SETUP*TCK);
            stream = {(convs_ss > ready_after), adc_word};
            idx = 0;
            pulses = 0;
        end else begin
            chk(($time - t_rise) == 2*HALF*TCK, "R4", "serial clock rise spacing ns",
                $time - t_rise, 2*HALF*TCK);
        end
        t_rise = $time;
        #1;
        if (idx <= DW) sdata = stream[DW-idx];
        else sdata = 0;
        idx++;
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic quiet(output bit saw_valid);
        int q = 0;
        saw_valid = 0;
        for (int i = 0; i < 3000 && q < 24; i++) begin
            @(negedge clk);
            if (valid) saw_valid = 1;
            if (!conv && !sclk) q++; else q = 0;
        end
    endtask

    task automatic mode_cmd(input logic [1:0] m, input bit with_start);
        @(negedge clk);
        mode = m; mset = 1; start = with_start;
        @(negedge clk);
        mset = 0; start = 0;
    endtask

    task automatic do_conv(input logic [DW-1:0] w, input bit exp_ref, input int hold);
        int waitc = 0;
        adc_word = w;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        while (!valid && waitc < 400) begin @(negedge clk); waitc++; end
        chk(valid, "R6", "result valid appears", valid, 1);
        chk(rdata == w, "R3", "result word", rdata, w);
        chk(rref == exp_ref, "R3", "result reference flag", rref, exp_ref);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(valid && rdata == w, "R6", "held result", rdata, w);
        end
        rdy = 1;
        @(negedge clk);
        rdy = 0;
        chk(!valid, "R6", "valid drops after accept", valid, 0);
    endtask

    initial begin
        int c0, k0;
        bit sv;
        cyc(1);
        // R1 reset state
        chk(!sclk && !conv && !valid && !werr, "R1", "outputs in reset",
            {sclk, conv, valid, werr}, 0);
        cyc(4);
        rst_n = 1;
        cyc(2);
        chk(!sclk && !conv && !valid && !werr, "R1", "outputs after reset",
            {sclk, conv, valid, werr}, 0);

        // R3 sweep of data words, mixed back-pressure (R6)
        for (int k = 0; k < 120; k++) begin
            logic [DW-1:0] w;
            case (k)
                0: w = '0;
                1: w = '1;
                2: w = 12'hAAA;
                3: w = 12'h555;
                default: w = DW'((k * 1237 + k * k * 31) % 4096);
            endcase
            if (k >= 4 && k < 16) w = DW'(1) << (k - 4);
            c0 = conv_rises; k0 = clk_rises;
            do_conv(w, 1'b1, k % 3);
            chk(conv_rises - c0 == 1, "R3", "one strobe per conversion", conv_rises - c0, 1);
            chk(clk_rises - k0 == DW + 2, "R3", "serial clock rises per conversion",
                clk_rises - k0, DW + 2);
        end

        // R5 start while result held and while shifting
        c0 = conv_rises;
        adc_word = 12'h3C5;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        cyc(20);
        start = 1; @(negedge clk); start = 0;
        while (!valid) @(negedge clk);
        cyc(3);
        start = 1; @(negedge clk); start = 0;
        mode = 2'd1; mset = 1; @(negedge clk); mset = 0;   // R11 busy mode command
        chk(valid && rdata == 12'h3C5, "R6", "held through ignored requests", rdata, 12'h3C5);
        rdy = 1; @(negedge clk); rdy = 0;
        quiet(sv);
        chk(conv_rises - c0 == 1, "R5", "strobes for one transaction", conv_rises - c0, 1);
        chk(!sv, "R5", "no extra result", sv, 0);

        // R7 nap
        c0 = conv_rises; k0 = clk_rises;
        mode_cmd(2'd1, 0);
        quiet(sv);
        chk(conv_rises - c0 == 2, "R7", "nap pulses", conv_rises - c0, 2);
        chk(clk_rises - k0 == 0, "R7", "nap clock rises", clk_rises - k0, 0);
        chk(!sv, "R7", "nap result", sv, 0);

        // R11 reserved code and start/mode collision
        c0 = conv_rises; k0 = clk_rises;
        mode_cmd(2'd3, 0);
        quiet(sv);
        chk(conv_rises - c0 == 0 && clk_rises - k0 == 0, "R11", "reserved code activity",
            conv_rises - c0 + clk_rises - k0, 0);
        c0 = conv_rises; k0 = clk_rises;
        mode_cmd(2'd1, 1);
        quiet(sv);
        chk(conv_rises - c0 == 2, "R11", "collision strobes", conv_rises - c0, 2);
        chk(clk_rises - k0 == 0 && !sv, "R11", "collision clock rises", clk_rises - k0, 0);

        // R8 sleep then R9 wake with ready after two conversions
        ready_after = 2;
        c0 = conv_rises; k0 = clk_rises;
        mode_cmd(2'd2, 0);
        quiet(sv);
        chk(conv_rises - c0 == 4, "R8", "sleep pulses", conv_rises - c0, 4);
        chk(clk_rises - k0 == 0 && !sv, "R8", "sleep clock rises", clk_rises - k0, 0);
        c0 = conv_rises; k0 = clk_rises;
        mode_cmd(2'd0, 0);
        quiet(sv);
        chk(conv_rises - c0 == 3, "R9", "wake conversions", conv_rises - c0, 3);
        chk(clk_rises - k0 == 3 * (DW + 2), "R9", "wake clock rises", clk_rises - k0, 3 * (DW + 2));
        chk(!sv, "R9", "wake presents no result", sv, 0);
        chk(!werr, "R9", "no error after good wake", werr, 0);
        do_conv(12'h7E1, 1'b1, 0);

        // R10 timeout
        ready_after = 100;
        mode_cmd(2'd2, 0);
        quiet(sv);
        c0 = conv_rises;
        mode_cmd(2'd0, 0);
        quiet(sv);
        chk(conv_rises - c0 == TRIES, "R10", "tries before timeout", conv_rises - c0, TRIES);
        chk(werr, "R10", "error flag set", werr, 1);
        do_conv(12'h123, 1'b0, 1);
        chk(werr, "R10", "error flag sticky", werr, 1);
        ready_after = 0;
        @(negedge clk); mode = 2'd0; mset = 1;
        @(negedge clk); mset = 0;
        chk(!werr, "R10", "error cleared on wake command", werr, 1'b0);
        quiet(sv);
        chk(!werr && !sv, "R9", "wake recovered", werr, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(TCK * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule